// File: doc/BRIEF.md
# Externally Locked Display Timing Counters

This block holds the three position counters of a display timing generator: a pixel counter along the line, a pixel-pair counter that steps once per two pixels for chroma, and a line counter down the frame. It also holds the current field. With no lock source the counters run freely. The pixel counter wraps at a programmed line length and advances the line counter. The line counter wraps at a programmed frame length, and the field flips at each frame wrap.

In external lock mode, the block follows an external video source. Horizontal and vertical sync inputs and an optional field pin pass through a two-flop synchronizer. Only a rising edge acts on the counters. A horizontal edge reloads the pixel and pair counters from programmed values. A vertical edge reloads the line counter, but only while the current field is field 1. The field comes from the field pin or from detect logic that looks at where in the line the vertical edge lands.

A port with a nonzero index can also follow the port one index below it. That master sends a restart strobe on the same pixel clock. The strobe clears every counter in the next cycle, so both ports stay in lockstep as long as they share their programmed values. Port 0 has no master and ignores the strobe.

Top module: `disp_lock_counters`

## Requirements
- R1: During reset and in the first cycle after it, the pixel, pair and line counters read 0 and the field output reads 0, where 0 means field 1 and 1 means field 2.
- R2: If no reload acts, the pixel counter counts up by one each clock. When it is at or above `line_len`-1, it goes to 0 and the line counter advances.
- R3: The pair counter goes up by one on each clock that takes the pixel counter from an odd value to the next value. It goes to 0 when the pixel counter wraps. It holds when the pixel counter leaves an even value.
- R4: With `ext_lock_en` high, a 0-to-1 change on `ext_hsync` loads `hrld` into the pixel counter and `crld` into the pair counter. The loaded values are visible after the third rising clock edge that samples the new level. Holding `ext_hsync` high causes no further load.
- R5: With `ext_lock_en` high, a rising `ext_vsync` loads `vrld` into the line counter when the field in effect is field 1, after the same three-edge delay. When the field in effect is field 2, the line counter continues unchanged.
- R6: With `ext_lock_en` and `field_from_pin` high, `field_two` follows `ext_field` (0 means field 1, 1 means field 2) after the third rising edge that samples a new level.
- R7: With `ext_lock_en` high and `field_from_pin` low, a rising `ext_vsync` selects field 1 if the pixel counter is below `line_len`/2 at that moment, and field 2 otherwise. The field holds between vertical edges.
- R8: With `ext_lock_en` low, the line counter wraps to 0 once it is at or above `frame_len`-1 and advances. `field_two` toggles at that wrap. The sync and field inputs have no effect.
- R9: On a port with `PORT_IDX` > 0, `master_restart` high while `port_follow_en` is high clears all three counters and selects field 1 at the next edge, with no synchronizer delay. This takes priority over every reload.
- R10: On port 0, `master_restart` has no effect, and the counters continue as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_lock_en | input | 1 | Follow the external sync inputs |
| field_from_pin | input | 1 | 1: field from `ext_field`, 0: field from detect logic |
| port_follow_en | input | 1 | Follow the master port's restart strobe |
| master_restart | input | 1 | Restart strobe from the lower-index port |
| ext_hsync | input | 1 | External horizontal sync, asynchronous |
| ext_vsync | input | 1 | External vertical sync, asynchronous |
| ext_field | input | 1 | External field level, asynchronous, 1 = field 2 |
| hrld | input | PIX_W | Pixel counter reload value |
| crld | input | PIX_W-1 | Pair counter reload value |
| vrld | input | LINE_W | Line counter reload value |
| line_len | input | PIX_W | Pixels per line |
| frame_len | input | LINE_W | Lines per frame |
| pix_cnt | output | PIX_W | Pixel counter |
| chroma_cnt | output | PIX_W-1 | Pixel-pair counter |
| line_cnt | output | LINE_W | Line counter |
| field_two | output | 1 | Current field, 1 = field 2 |

## Verification
The restart strobe and free counting both show up one edge after the edge that samples them. Anything arriving on the external sync or field pins shows up after the third edge: two synchronizer stages and one counter stage. The bench changes inputs and reads outputs only on falling edges. A reference model in the bench carries the same three-stage pipeline, so each compared value lines up with the edge where the design updates. The directed cases wait for exactly that many falling edges. They also check the values just before the change, so an off-by-one in latency shows up as a failure.

// File: rtl/disp_lock_pkg.sv
package disp_lock_pkg;
    typedef enum logic {
        FIELD_ONE = 1'b0,
        FIELD_TWO = 1'b1
    } field_e;
endpackage

// File: rtl/disp_sync_in.sv
// Multi-stage synchronizer for one asynchronous level.
module disp_sync_in #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign level = chain_q[STAGES-1];
endmodule

// File: rtl/disp_field_sel.sv
// Picks the field in effect this cycle: pin level or position-based detect.
module disp_field_sel
    import disp_lock_pkg::*;
#(
    parameter int PIX_W = 12
) (
    input  logic             pin_mode,
    input  logic             pin_lvl,
    input  logic             vs_edge,
    input  logic [PIX_W-1:0] pix,
    input  logic [PIX_W-1:0] half,
    input  field_e           cur,
    output field_e           nxt
);
    always_comb begin
        if (pin_mode) begin
            nxt = pin_lvl ? FIELD_TWO : FIELD_ONE;
        end else if (vs_edge) begin
            nxt = (pix < half) ? FIELD_ONE : FIELD_TWO;
        end else begin
            nxt = cur;
        end
    end
endmodule

// File: rtl/disp_lock_counters.sv
module disp_lock_counters
    import disp_lock_pkg::*;
#(
    parameter int PIX_W    = 12,
    parameter int LINE_W   = 11,
    parameter int SYNC_STG = 2,
    parameter int PORT_IDX = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_lock_en,
    input  logic              field_from_pin,
    input  logic              port_follow_en,
    input  logic              master_restart,
    input  logic              ext_hsync,
    input  logic              ext_vsync,
    input  logic              ext_field,
    input  logic [PIX_W-1:0]  hrld,
    input  logic [PIX_W-2:0]  crld,
    input  logic [LINE_W-1:0] vrld,
    input  logic [PIX_W-1:0]  line_len,
    input  logic [LINE_W-1:0] frame_len,
    output logic [PIX_W-1:0]  pix_cnt,
    output logic [PIX_W-2:0]  chroma_cnt,
    output logic [LINE_W-1:0] line_cnt,
    output logic              field_two
);
    localparam int  CHR_W    = PIX_W - 1;
    localparam bit  IS_SLAVE = (PORT_IDX > 0);

    typedef struct packed {
        logic [PIX_W-1:0]  pix;
        logic [CHR_W-1:0]  chr;
        logic [LINE_W-1:0] line;
        field_e            fld;
        logic              hs_prev;
        logic              vs_prev;
    } cnt_t;

    cnt_t st_q, st_d;

    logic       hs_lvl, vs_lvl, fd_lvl;
    logic       hs_rise, vs_rise;
    logic       follow_hit;
    logic       pix_end, line_end;
    logic       hs_load, vs_load, line_adv;
    logic [PIX_W-1:0] half;
    field_e     field_now;

    disp_sync_in #(.STAGES(SYNC_STG)) u_hs_sync (
        .clk(clk), .rst_n(rst_n), .din(ext_hsync), .level(hs_lvl)
    );
    disp_sync_in #(.STAGES(SYNC_STG)) u_vs_sync (
        .clk(clk), .rst_n(rst_n), .din(ext_vsync), .level(vs_lvl)
    );
    disp_sync_in #(.STAGES(SYNC_STG)) u_fd_sync (
        .clk(clk), .rst_n(rst_n), .din(ext_field), .level(fd_lvl)
    );

    generate
        if (IS_SLAVE) begin : g_follow
            assign follow_hit = port_follow_en & master_restart;
        end else begin : g_master
            assign follow_hit = 1'b0;
        end
    endgenerate

    assign hs_rise  = hs_lvl & ~st_q.hs_prev;
    assign vs_rise  = vs_lvl & ~st_q.vs_prev;
    assign half     = line_len >> 1;
    assign pix_end  = (st_q.pix >= line_len - 1'b1);
    assign line_end = (st_q.line >= frame_len - 1'b1);

    disp_field_sel #(.PIX_W(PIX_W)) u_field_sel (
        .pin_mode (field_from_pin),
        .pin_lvl  (fd_lvl),
        .vs_edge  (vs_rise),
        .pix      (st_q.pix),
        .half     (half),
        .cur      (st_q.fld),
        .nxt      (field_now)
    );

    always_comb begin
        hs_load  = ext_lock_en & hs_rise;
        vs_load  = ext_lock_en & vs_rise & (field_now == FIELD_ONE);
        line_adv = ~hs_load & pix_end;

        st_d         = st_q;
        st_d.hs_prev = hs_lvl;
        st_d.vs_prev = vs_lvl;

        if (follow_hit) begin
            st_d.pix  = '0;
            st_d.chr  = '0;
            st_d.line = '0;
            st_d.fld  = FIELD_ONE;
        end else begin
            if (hs_load) begin
                st_d.pix = hrld;
                st_d.chr = crld;
            end else if (pix_end) begin
                st_d.pix = '0;
                st_d.chr = '0;
            end else begin
                st_d.pix = st_q.pix + 1'b1;
                st_d.chr = st_q.chr + CHR_W'(st_q.pix[0]);
            end

            if (vs_load) begin
                st_d.line = vrld;
            end else if (line_adv) begin
                st_d.line = line_end ? '0 : st_q.line + 1'b1;
            end

            if (ext_lock_en) begin
                st_d.fld = field_now;
            end else if (line_adv && line_end) begin
                st_d.fld = (st_q.fld == FIELD_ONE) ? FIELD_TWO : FIELD_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pix: '0, chr: '0, line: '0, fld: FIELD_ONE,
                      hs_prev: 1'b0, vs_prev: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_cnt    = st_q.pix;
    assign chroma_cnt = st_q.chr;
    assign line_cnt   = st_q.line;
    assign field_two  = (st_q.fld == FIELD_TWO);
endmodule

// File: rtl/disp_lock_counters_chk.sv
module disp_lock_counters_chk #(
    parameter int PIX_W  = 12,
    parameter int LINE_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ext_lock_en,
    input logic              field_from_pin,
    input logic              hs_rise,
    input logic              follow_hit,
    input logic              fd_lvl,
    input logic [PIX_W-1:0]  hrld,
    input logic [PIX_W-2:0]  crld,
    input logic [PIX_W-1:0]  line_len,
    input logic [PIX_W-1:0]  pix_cnt,
    input logic [PIX_W-2:0]  chroma_cnt,
    input logic [LINE_W-1:0] line_cnt,
    input logic              field_two
);
    AST_FOLLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        follow_hit |=> (pix_cnt == '0 && chroma_cnt == '0 && line_cnt == '0 && !field_two)); // R9

    AST_HSYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_lock_en && hs_rise && !follow_hit) |=>
            (pix_cnt == $past(hrld) && chroma_cnt == $past(crld))); // R4

    AST_FIELD_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_lock_en && field_from_pin && !follow_hit) |=> (field_two == $past(fd_lvl))); // R6

    AST_PIX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!follow_hit && !(ext_lock_en && hs_rise) && pix_cnt >= line_len - 1'b1) |=>
            (pix_cnt == '0 && chroma_cnt == '0)); // R2

    AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!follow_hit && !(ext_lock_en && hs_rise) && pix_cnt < line_len - 1'b1 && !pix_cnt[0]) |=>
            $stable(chroma_cnt)); // R3
endmodule

bind disp_lock_counters disp_lock_counters_chk #(
    .PIX_W (PIX_W),
    .LINE_W(LINE_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ext_lock_en   (ext_lock_en),
    .field_from_pin(field_from_pin),
    .hs_rise       (hs_rise),
    .follow_hit    (follow_hit),
    .fd_lvl        (fd_lvl),
    .hrld          (hrld),
    .crld          (crld),
    .line_len      (line_len),
    .pix_cnt       (pix_cnt),
    .chroma_cnt    (chroma_cnt),
    .line_cnt      (line_cnt),
    .field_two     (field_two)
);

// File: tb/disp_lock_counters_bench.sv
module disp_lock_counters_bench;
    localparam int PW = 12;
    localparam int LW = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_lock_en = 0, field_from_pin = 0, port_follow_en = 0, master_restart = 0;
    logic ext_hsync = 0, ext_vsync = 0, ext_field = 0;
    logic [PW-1:0] hrld = '0, line_len = 12'd20;
    logic [PW-2:0] crld = '0;
    logic [LW-1:0] vrld = '0, frame_len = 11'd5;
    logic [PW-1:0] pix_cnt, p0_pix;
    logic [PW-2:0] chroma_cnt, p0_chr;
    logic [LW-1:0] line_cnt, p0_line;
    logic          field_two, p0_fld;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    disp_lock_counters #(.PIX_W(PW), .LINE_W(LW), .PORT_IDX(1)) u_disp_lock_counters (
        .clk(clk), .rst_n(rst_n), .ext_lock_en(ext_lock_en), .field_from_pin(field_from_pin),
        .port_follow_en(port_follow_en), .master_restart(master_restart),
        .ext_hsync(ext_hsync), .ext_vsync(ext_vsync), .ext_field(ext_field),
        .hrld(hrld), .crld(crld), .vrld(vrld), .line_len(line_len), .frame_len(frame_len),
        .pix_cnt(pix_cnt), .chroma_cnt(chroma_cnt), .line_cnt(line_cnt), .field_two(field_two)
    );

    disp_lock_counters #(.PIX_W(PW), .LINE_W(LW), .PORT_IDX(0)) u_disp_lock_counters_p0 (
        .clk(clk), .rst_n(rst_n), .ext_lock_en(ext_lock_en), .field_from_pin(field_from_pin),
        .port_follow_en(port_follow_en), .master_restart(master_restart),
        .ext_hsync(ext_hsync), .ext_vsync(ext_vsync), .ext_field(ext_field),
        .hrld(hrld), .crld(crld), .vrld(vrld), .line_len(line_len), .frame_len(frame_len),
        .pix_cnt(p0_pix), .chroma_cnt(p0_chr), .line_cnt(p0_line), .field_two(p0_fld)
    );

    // Reference model of the slave port, built from the requirements.
    logic [PW-1:0] m_pix;
    logic [PW-2:0] m_chr;
    logic [LW-1:0] m_line;
    logic          m_fld;
    logic          m_h1, m_h2, m_hp, m_v1, m_v2, m_vp, m_f1, m_f2;

    function automatic logic next_field(input logic pin_mode, input logic pin_lvl,
                                        input logic vedge, input logic [PW-1:0] pix,
                                        input logic [PW-1:0] len, input logic cur);
        if (pin_mode) return pin_lvl;
        if (vedge)    return (pix < (len >> 1)) ? 1'b0 : 1'b1;
        return cur;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pix <= '0; m_chr <= '0; m_line <= '0; m_fld <= 1'b0;
            m_h1 <= 0; m_h2 <= 0; m_hp <= 0; m_v1 <= 0; m_v2 <= 0; m_vp <= 0;
            m_f1 <= 0; m_f2 <= 0;
        end else begin
            logic hr, vr, fnow, hl, vl, pend, lend, adv;
            hr   = m_h2 & ~m_hp;
            vr   = m_v2 & ~m_vp;
            fnow = next_field(field_from_pin, m_f2, vr, m_pix, line_len, m_fld);
            hl   = ext_lock_en & hr;
            vl   = ext_lock_en & vr & ~fnow;
            pend = (m_pix >= line_len - 1'b1);
            lend = (m_line >= frame_len - 1'b1);
            adv  = ~hl & pend;
            m_h1 <= ext_hsync; m_h2 <= m_h1; m_hp <= m_h2;
            m_v1 <= ext_vsync; m_v2 <= m_v1; m_vp <= m_v2;
            m_f1 <= ext_field; m_f2 <= m_f1;
            if (port_follow_en && master_restart) begin
                m_pix <= '0; m_chr <= '0; m_line <= '0; m_fld <= 1'b0;
            end else begin
                if (hl)        begin m_pix <= hrld; m_chr <= crld; end
                else if (pend) begin m_pix <= '0;   m_chr <= '0;   end
                else begin m_pix <= m_pix + 1'b1; m_chr <= m_chr + {10'd0, m_pix[0]}; end
                if (vl)       m_line <= vrld;
                else if (adv) m_line <= lend ? '0 : m_line + 1'b1;
                if (ext_lock_en)      m_fld <= fnow;
                else if (adv && lend) m_fld <= ~m_fld;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic compare_model();
        check("R2", "pixel vs model", pix_cnt, m_pix);
        check("R3", "pair vs model", chroma_cnt, m_chr);
        check("R5", "line vs model", line_cnt, m_line);
        check("R7", "field vs model", field_two, m_fld);
    endtask

    initial begin
        int v;
        int lsave;
        void'($urandom(32'd4242));
        wait_neg(2);
        // R1: reset state
        check("R1", "pixel at reset", pix_cnt, 0);
        check("R1", "pair at reset", chroma_cnt, 0);
        check("R1", "line at reset", line_cnt, 0);
        check("R1", "field at reset", field_two, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "pixel after first edge", pix_cnt, 1);

        // Random phases checked against the model
        for (int ph = 0; ph < 12; ph++) begin
            ext_lock_en    = $urandom_range(0, 2) != 0;
            field_from_pin = $urandom_range(0, 1);
            port_follow_en = $urandom_range(0, 1);
            line_len  = 12'($urandom_range(4, 24));
            frame_len = 11'($urandom_range(2, 8));
            hrld = 12'($urandom_range(0, 30));
            crld = 11'($urandom_range(0, 15));
            vrld = 11'($urandom_range(0, 10));
            for (int c = 0; c < 400; c++) begin
                @(negedge clk);
                compare_model();
                if ($urandom_range(0, 7) == 0) ext_hsync = ~ext_hsync;
                if ($urandom_range(0, 11) == 0) ext_vsync = ~ext_vsync;
                if ($urandom_range(0, 15) == 0) ext_field = ~ext_field;
                master_restart = ($urandom_range(0, 39) == 0);
            end
        end

        // Directed: R4 horizontal reload and its latency
        ext_hsync = 0; ext_vsync = 0; ext_field = 0; master_restart = 0;
        port_follow_en = 0; ext_lock_en = 1; field_from_pin = 1;
        line_len = 12'd200; frame_len = 11'd50; hrld = 12'd40; crld = 11'd7; vrld = 11'd5;
        wait_neg(6);
        ext_hsync = 1;
        wait_neg(2);
        check("R4", "no load before third edge", (pix_cnt == 40) ? 1 : 0, 0);
        wait_neg(1);
        check("R4", "pixel reload", pix_cnt, 40);
        check("R4", "pair reload", chroma_cnt, 7);
        wait_neg(5);
        check("R4", "held sync does not reload", pix_cnt, 45);
        check("R3", "pair after 40..45", chroma_cnt, 9);
        ext_hsync = 0;

        // R5 vertical reload in field 1
        ext_vsync = 1;
        wait_neg(3);
        check("R5", "line reload in field 1", line_cnt, 5);
        ext_vsync = 0;
        // R6 field from pin, three-edge delay
        ext_field = 1;
        wait_neg(2);
        check("R6", "field before pin delay", field_two, 0);
        wait_neg(1);
        check("R6", "field follows pin", field_two, 1);
        wait_neg(2);
        lsave = line_cnt;
        ext_vsync = 1;
        wait_neg(3);
        check("R5", "no line reload in field 2", line_cnt, lsave);
        ext_vsync = 0;

        // R7 detect: early edge -> field 1, late edge -> field 2
        field_from_pin = 0; ext_field = 0; hrld = 12'd10; vrld = 11'd3;
        wait_neg(4);
        ext_hsync = 1; wait_neg(3); ext_hsync = 0;
        wait_neg(2);
        ext_vsync = 1; wait_neg(3);
        check("R7", "early vsync gives field 1", field_two, 0);
        check("R5", "detect field 1 reloads line", line_cnt, 3);
        ext_vsync = 0; wait_neg(3);
        hrld = 12'd150;
        ext_hsync = 1; wait_neg(3); ext_hsync = 0;
        ext_vsync = 1; wait_neg(3);
        check("R7", "late vsync gives field 2", field_two, 1);
        ext_vsync = 0;

        // R9 restart strobe, R10 port 0 ignores it, R8 free-run field toggle
        ext_lock_en = 0; line_len = 12'd4; frame_len = 11'd2;
        wait_neg(3);
        port_follow_en = 1; master_restart = 1;
        v = p0_pix;
        @(negedge clk);
        master_restart = 0;
        check("R9", "pixel cleared", pix_cnt, 0);
        check("R9", "line cleared", line_cnt, 0);
        check("R9", "field reset to 1", field_two, 0);
        check("R10", "port 0 ignores strobe", p0_pix, (v >= 3) ? 0 : v + 1);
        ext_hsync = 1; ext_vsync = 1; ext_field = 1;
        wait_neg(7);
        check("R8", "field before frame wrap", field_two, 0);
        check("R8", "sync ignored in free run", pix_cnt, 3);
        wait_neg(1);
        check("R8", "field toggles at frame wrap", field_two, 1);
        check("R8", "line wraps", line_cnt, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule